// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Controller

This block watches seven external interrupt sources and keeps one sticky pending flag per source. Six of them are single pins. Each of these six has a programmable trigger polarity. Four of them can instead trigger on every transition. Two of them can be sent through a digital glitch filter before the edge is taken. The seventh source is an aggregate of several key lines. It combines every key line that its mask enables, and it fires when that combined level drops. Software configures the block, reads the flags and acknowledges them over a small register bus. The flags are also driven out as level request lines, which an interrupt arbiter elsewhere on the chip can consume.

Every input passes through a two-stage synchroniser before it reaches edge detection. An edge is found by comparing the current conditioned level with the level one cycle earlier. The trigger configuration is applied only after that comparison. As a result, reprogramming the trigger never creates a false request.

Top module: `eic_top`

## Requirements
- R1: After reset every configuration register reads 0, and all pending flags and request outputs are 0.
- R2: Register map, with reads returning data combinationally for the address presented. Address 0 holds the polarity bits, where bit i is pin channel i (0..5) and 1 selects the rising edge. Address 1 holds the any-edge enables, where bit j is channel j+2. Address 2 holds the filter enables, where bit 0 is channel 0 and bit 1 is channel 1. Address 3 holds the key mask, where bit k enables key line k. Address 4 holds the flags, where bit i is channel i and bit 6 is the key channel. Bits with no function read 0, and so do unused addresses.
- R3: A pin channel that has no any-edge enable and no filter enabled sets its flag only on the edge its polarity bit selects. The flag is visible at the output after the third rising clock edge that follows the pin change.
- R4: A channel 2..5 with its any-edge bit set raises its flag on both rising and falling pin transitions, with the same latency as R3.
- R5: With its filter enabled, channel 0 or 1 accepts a new level only after that level has been seen for 4 consecutive clock samples. A pulse 3 samples long is ignored. A pulse 4 samples long is accepted, and its flag appears after the seventh clock edge.
- R6: The key channel flag is set when the OR of the enabled key lines goes from 1 to 0, and this includes a drop caused by clearing a mask bit while that line is high. Masked-off lines have no effect, and a drop of one enabled line while another enabled line stays high does not set the flag.
- R7: Flags are sticky. Writing to address 4 clears exactly the flags whose data bit is 1, and writing 0 bits leaves the flags unchanged.
- R8: When a flag is set by an edge in the same cycle that a clear for that flag is written, the flag stays set.
- R9: Writing to the polarity, any-edge or filter register while the inputs are steady sets no flag.
- R10: A read of address 4 returns the same value as the request outputs, and bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the filter sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPin | input | 6 | Asynchronous interrupt pins, channels 0..5 |
| keyPin | input | NUM_KEYS (8) | Asynchronous key lines feeding channel 6 |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| irqReq | output | 7 | Pending flag per channel, bit 6 is the key channel |

## Verification
The cause assertions on channels 2..5 rely on a fixed pipeline. They check that a new request is tied to a pin transition three and four samples back, under the configuration one cycle back. This only holds if the pins are not changing during reset. The bench therefore keeps every pin low while reset is asserted. It also changes pins only at falling clock edges, and only after the previous transition has passed through the synchroniser. Register writes are likewise driven one per cycle at falling edges, so each write lands on a single known rising edge. This is how the set-versus-clear case can be lined up with the edge-detection cycle.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int NUM_CH      = 7;
  localparam int NUM_EDGE_CH = 6;
  localparam int KEY_CH      = 6;
  localparam int BOTH_BASE   = 2;
  localparam int NUM_BOTH    = 4;
  localparam int NUM_FILT    = 2;
  localparam int ADDR_W      = 3;
  localparam int DATA_W      = 8;

  localparam logic [ADDR_W-1:0] ADDR_POL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_BOTH = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FILT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_KEY  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;

  typedef struct packed {
    logic [NUM_EDGE_CH-1:0] pol;
    logic [NUM_BOTH-1:0]    both;
    logic [NUM_FILT-1:0]    filtEn;
  } cfg_t;

  typedef struct packed {
    logic              clrEn;
    logic [NUM_CH-1:0] clrMask;
  } strobe_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/eic_filter.sv
module eic_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [CNT_W-1:0] runCnt;

  // A differing sample advances the run; a matching one restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      dout   <= 1'b0;
    end else if (din == dout) begin
      runCnt <= '0;
    end else if (runCnt == CNT_LAST) begin
      runCnt <= '0;
      dout   <= din;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/eic_control.sv
module eic_control import eic_pkg::*; #(
  parameter int NUM_KEYS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic [NUM_CH-1:0]   flags,
  output cfg_t                cfg,
  output logic [NUM_KEYS-1:0] keyMask,
  output strobe_t             strb,
  output logic [DATA_W-1:0]   regRdata
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      keyMask <= '0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_POL:  cfg.pol    <= regWdata[NUM_EDGE_CH-1:0];
        ADDR_BOTH: cfg.both   <= regWdata[NUM_BOTH-1:0];
        ADDR_FILT: cfg.filtEn <= regWdata[NUM_FILT-1:0];
        ADDR_KEY:  keyMask    <= regWdata[NUM_KEYS-1:0];
        default: ;
      endcase
    end
  end

  assign strb.clrEn   = regWe && (regAddr == ADDR_FLAG);
  assign strb.clrMask = regWdata[NUM_CH-1:0];

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_POL:  regRdata[NUM_EDGE_CH-1:0] = cfg.pol;
      ADDR_BOTH: regRdata[NUM_BOTH-1:0]    = cfg.both;
      ADDR_FILT: regRdata[NUM_FILT-1:0]    = cfg.filtEn;
      ADDR_KEY:  regRdata[NUM_KEYS-1:0]    = keyMask;
      ADDR_FLAG: regRdata[NUM_CH-1:0]      = flags;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/eic_datapath.sv
module eic_datapath import eic_pkg::*; #(
  parameter int NUM_KEYS = 8,
  parameter int FILT_LEN = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_EDGE_CH-1:0] irqPin,
  input  logic [NUM_KEYS-1:0]    keyPin,
  input  cfg_t                   cfg,
  input  logic [NUM_KEYS-1:0]    keyMask,
  input  strobe_t                strb,
  output logic [NUM_CH-1:0]      flags
);
  logic [NUM_EDGE_CH-1:0] pinSync;
  logic [NUM_KEYS-1:0]    keySync;
  logic [NUM_CH-1:0]      level, levelPrev, fall, setVec, clrVec;
  logic [NUM_EDGE_CH-1:0] rise;

  eic_sync #(.WIDTH(NUM_EDGE_CH)) u_pinSync (
    .clk(clk), .rstN(rstN), .din(irqPin), .dout(pinSync));
  eic_sync #(.WIDTH(NUM_KEYS)) u_keySync (
    .clk(clk), .rstN(rstN), .din(keyPin), .dout(keySync));

  for (genvar ch = 0; ch < NUM_EDGE_CH; ch++) begin : g_edge
    if (ch < NUM_FILT) begin : g_filt
      logic filtLevel;
      eic_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rstN(rstN), .din(pinSync[ch]), .dout(filtLevel));
      assign level[ch] = cfg.filtEn[ch] ? filtLevel : pinSync[ch];
    end else begin : g_raw
      assign level[ch] = pinSync[ch];
    end

    if (ch >= BOTH_BASE && ch < BOTH_BASE + NUM_BOTH) begin : g_both
      assign setVec[ch] = cfg.both[ch-BOTH_BASE] ? (rise[ch] | fall[ch])
                        : (cfg.pol[ch] ? rise[ch] : fall[ch]);
    end else begin : g_single
      assign setVec[ch] = cfg.pol[ch] ? rise[ch] : fall[ch];
    end
  end

  assign level[KEY_CH]  = |(keySync & keyMask);
  assign setVec[KEY_CH] = fall[KEY_CH];

  // Edges come from level history only, so config writes cannot fake one.
  assign rise   = level[NUM_EDGE_CH-1:0] & ~levelPrev[NUM_EDGE_CH-1:0];
  assign fall   = ~level & levelPrev;
  assign clrVec = strb.clrEn ? strb.clrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelPrev <= '0;
      flags     <= '0;
    end else begin
      levelPrev <= level;
      flags     <= (flags & ~clrVec) | setVec;
    end
  end
endmodule

// File: rtl/eic_top.sv
module eic_top import eic_pkg::*; #(
  parameter int NUM_KEYS = 8,
  parameter int FILT_LEN = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_EDGE_CH-1:0] irqPin,
  input  logic [NUM_KEYS-1:0]    keyPin,
  input  logic                   regWe,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  output logic [NUM_CH-1:0]      irqReq
);
  cfg_t                cfg;
  strobe_t             strb;
  logic [NUM_KEYS-1:0] keyMask;

  eic_control #(.NUM_KEYS(NUM_KEYS)) u_control (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .flags(irqReq), .cfg(cfg), .keyMask(keyMask),
    .strb(strb), .regRdata(regRdata));

  eic_datapath #(.NUM_KEYS(NUM_KEYS), .FILT_LEN(FILT_LEN)) u_datapath (
    .clk(clk), .rstN(rstN), .irqPin(irqPin), .keyPin(keyPin), .cfg(cfg),
    .keyMask(keyMask), .strb(strb), .flags(irqReq));
endmodule

// File: rtl/eic_checker.sv
module eic_checker import eic_pkg::*; (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_BOTH-1:0] pinMid,
  input logic [NUM_CH-1:0]   irqReq,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [NUM_CH-1:0]   clrBits,
  input logic [DATA_W-1:0]   regRdata,
  input logic [NUM_BOTH-1:0] polMid,
  input logic [NUM_BOTH-1:0] bothMid
);
  logic [NUM_CH-1:0] clrNow;
  assign clrNow = (regWe && regAddr == ADDR_FLAG) ? clrBits : '0;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(irqReq) & ~irqReq & ~$past(clrNow)) == '0)); // R7

  AST_FLAG_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_FLAG) |-> (regRdata == DATA_W'(irqReq))); // R10

  for (genvar j = 0; j < NUM_BOTH; j++) begin : g_mid
    AST_ANY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqReq[BOTH_BASE+j]) |-> ($past(pinMid[j], 3) != $past(pinMid[j], 4))); // R4

    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(irqReq[BOTH_BASE+j]) && !$past(bothMid[j]) && $past(polMid[j]))
      |-> ($past(pinMid[j], 3) && !$past(pinMid[j], 4))); // R3

    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(irqReq[BOTH_BASE+j]) && !$past(bothMid[j]) && !$past(polMid[j]))
      |-> (!$past(pinMid[j], 3) && $past(pinMid[j], 4))); // R3
  end
endmodule

bind eic_top eic_checker u_chk (
  .clk(clk), .rstN(rstN),
  .pinMid(irqPin[eic_pkg::BOTH_BASE+eic_pkg::NUM_BOTH-1:eic_pkg::BOTH_BASE]),
  .irqReq(irqReq), .regWe(regWe), .regAddr(regAddr),
  .clrBits(regWdata[eic_pkg::NUM_CH-1:0]), .regRdata(regRdata),
  .polMid(cfg.pol[eic_pkg::BOTH_BASE+eic_pkg::NUM_BOTH-1:eic_pkg::BOTH_BASE]),
  .bothMid(cfg.both));

// File: tb/test_eic_top.sv
module test_eic_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] irqPin = '0;
  logic [7:0] keyPin = '0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [6:0] irqReq;

  int errors = 0;
  int checks = 0;
  logic [7:0] rd;

  eic_top i_eic_top (
    .clk(clk), .rstN(rstN), .irqPin(irqPin), .keyPin(keyPin),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqReq(irqReq));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    step(4);
    rstN = 1'b1;
    step(1);
    // R1: reset state
    chk("R1 irqReq", irqReq, 0);
    for (int a = 0; a < 5; a++) begin
      rdReg(3'(a), rd);
      chk("R1 reg", rd, 0);
    end
    // R2: readback with unused bits zero
    wrReg(0, 8'hFF); wrReg(1, 8'hFF); wrReg(2, 8'hFF); wrReg(3, 8'hFF);
    rdReg(0, rd); chk("R2 pol", rd, 8'h3F);
    rdReg(1, rd); chk("R2 both", rd, 8'h0F);
    rdReg(2, rd); chk("R2 filt", rd, 8'h03);
    rdReg(3, rd); chk("R2 key", rd, 8'hFF);
    rdReg(5, rd); chk("R2 unused", rd, 0);
    wrReg(0, 0); wrReg(1, 0); wrReg(2, 0); wrReg(3, 0);
    step(3);
    chk("R9 cfg writes", irqReq, 0);

    // R3/R4/R9 sweep over channel, polarity, any-edge and direction
    for (int ch = 0; ch < 6; ch++)
      for (int pol = 0; pol < 2; pol++)
        for (int bo = 0; bo < 2; bo++)
          for (int dir = 0; dir < 2; dir++) begin
            logic [6:0] exp;
            irqPin[ch] = (dir == 0);
            step(5);
            wrReg(4, 8'h7F);
            wrReg(0, (pol != 0) ? 8'(1 << ch) : 8'h00);
            wrReg(1, (bo != 0 && ch >= 2) ? 8'(1 << (ch - 2)) : 8'h00);
            step(3);
            chk("R9 no spurious flag", irqReq, 0);
            irqPin[ch] = (dir != 0);
            step(2);
            chk("R3 latency", irqReq, 0);
            step(1);
            exp = ((ch >= 2 && bo != 0) || (pol == dir)) ? 7'(1 << ch) : 7'h00;
            chk((bo != 0 && ch >= 2) ? "R4 any edge" : "R3 polarity", irqReq, exp);
            rdReg(4, rd);
            chk("R10 flag read", rd, {1'b0, irqReq});
          end

    // R5: noise filter on channel 0, rising
    irqPin = '0;
    step(5);
    wrReg(1, 0); wrReg(0, 8'h03); wrReg(2, 8'h01);
    step(6);
    wrReg(4, 8'h7F);
    irqPin[0] = 1'b1; step(3); irqPin[0] = 1'b0;
    step(10);
    chk("R5 short pulse rejected", irqReq, 0);
    irqPin[0] = 1'b1; step(4); irqPin[0] = 1'b0;
    step(2);
    chk("R5 filter latency", irqReq, 0);
    step(1);
    chk("R5 4-sample pulse accepted", irqReq, 7'h01);
    step(10);
    wrReg(4, 8'h7F);
    // channel 1 unfiltered: one-cycle pulse is taken
    irqPin[1] = 1'b1; step(1); irqPin[1] = 1'b0;
    step(1);
    chk("R5 unfiltered latency", irqReq, 0);
    step(1);
    chk("R5 unfiltered pulse", irqReq, 7'h02);
    step(4);
    wrReg(4, 8'h7F);

    // R6: key scan with mask 0x05
    wrReg(3, 8'h05);
    step(3);
    keyPin[1] = 1'b1; step(4); keyPin[1] = 1'b0; step(4);
    chk("R6 masked line ignored", irqReq, 0);
    keyPin[0] = 1'b1; step(4);
    chk("R6 rise ignored", irqReq, 0);
    keyPin[2] = 1'b1; step(2); keyPin[0] = 1'b0; step(4);
    chk("R6 OR still high", irqReq, 0);
    keyPin[2] = 1'b0; step(2);
    chk("R6 latency", irqReq, 0);
    step(1);
    chk("R6 combined fall", irqReq, 7'h40);

    // R7: sticky flags and write-one-to-clear
    irqPin[1] = 1'b1; step(1); irqPin[1] = 1'b0; step(4);
    chk("R7 two flags", irqReq, 7'h42);
    wrReg(4, 8'h00);
    chk("R7 zero write keeps", irqReq, 7'h42);
    wrReg(4, 8'h40);
    chk("R7 selective clear", irqReq, 7'h02);
    wrReg(4, 8'h02);
    chk("R7 clear rest", irqReq, 0);

    // R8: set beats clear on channel 3, rising
    wrReg(0, 8'h08);
    step(2);
    irqPin[3] = 1'b1; step(3);
    chk("R8 setup flag", irqReq, 7'h08);
    irqPin[3] = 1'b0; step(4);
    chk("R7 falling ignored, sticky", irqReq, 7'h08);
    irqPin[3] = 1'b1; step(2);
    wrReg(4, 8'h08);
    chk("R8 set wins over clear", irqReq, 7'h08);
    wrReg(4, 8'h08);
    chk("R7 clear after", irqReq, 0);
    rdReg(4, rd);
    chk("R10 flag read zero", rd, 0);

    finishRun();
  end
endmodule